// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block drives the bus cycles that carry an 8-bit processor with a 16-bit address space into an interrupt handler and back out of it. When an entry request is accepted, it first issues a configurable number of dummy read cycles. It then writes a five-byte frame onto a stack that grows downward: the return address (the current program counter minus one), the index register, the accumulator and the condition code byte. Next it sets the interrupt mask bit in the condition code output. It reads the two vector bytes, high byte first, and finally places the assembled handler address on the bus.

A return request reads the same frame back in the opposite direction, from the lowest stack byte upward. Each register output is reloaded as its byte arrives, and the sequencer then fetches from the restored program counter. Because the condition code byte is restored, the mask bit returns to whatever it was before entry. Opcode decoding and the handler itself belong to the surrounding core. The core gives this block the live register values and takes back the restored ones.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is asserted and until the first request after it, `busy` and `done` are 0, `rw` is 1 and `pc_out`, `x_out`, `a_out`, `ccr_out` and `sp_out` are all 0.
- R2: Requests are sampled only while idle. If `start_entry` and `start_return` are both high, entry is taken. Either request raised while `busy` is 1 changes neither the bus sequence nor the outputs.
- R3: An entry begins with DUMMY_CYC read cycles addressed at the sampled SP. Then come exactly five consecutive write cycles (`rw`=0): (PC-1)[7:0] at SP, (PC-1)[15:8] at SP-1, X at SP-2, A at SP-3 and CCR at SP-4, with addresses wrapping modulo 2^16. `rw` is 0 in no other cycle.
- R4: From the cycle after the last entry write, `ccr_out` equals the sampled CCR with bit MASK_BIT set, and `sp_out` equals SP-5 modulo 2^16.
- R5: After the writes, the block reads the vector high byte at `vec_in` and then the low byte at `vec_in`+1. `pc_out` becomes {high, low}.
- R6: A return reads SP+1, SP+2, SP+3, SP+4 and SP+5 (modulo 2^16) in that order, loading `ccr_out`, `a_out`, `x_out`, the PC high byte and the PC low byte. Each output is updated at the clock edge that ends its read. `sp_out` becomes SP+5.
- R7: The last cycle of either sequence is a read with `done`=1 whose address equals `pc_out`, the new program counter. `done` is high for exactly one cycle and the block is idle in the next cycle.
- R8: While idle, `addr` follows `pc_in`, `rw` is 1, `done` is 0 and `data_out` is 0.
- R9: The mask bit in `ccr_out` after a return is the mask bit of the popped byte, so it is cleared when that byte has it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_entry | input | 1 | Request to perform interrupt entry |
| start_return | input | 1 | Request to perform interrupt return |
| vec_in | input | 16 | Address of the vector high byte |
| pc_in | input | 16 | Live program counter |
| x_in | input | 8 | Live index register |
| a_in | input | 8 | Live accumulator |
| ccr_in | input | 8 | Live condition code byte |
| sp_in | input | 16 | Live stack pointer |
| data_in | input | 8 | Read data from memory |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| data_out | output | 8 | Write data |
| done | output | 1 | One-cycle pulse on the first fetch at the new PC |
| busy | output | 1 | A sequence is in progress |
| pc_out | output | 16 | Restored or handler program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 8 | Condition code byte with mask set or restored |
| sp_out | output | 16 | Adjusted stack pointer |

## Verification
The bench builds the block with DUMMY_CYC=3 and MASK_BIT=3. The dummy phase is therefore longer than two cycles, and the step counter has to count through a run that differs from the five-byte frame. A stack pointer of 0x0002 makes the entry writes wrap below zero and the matching return reads wrap back up past 0xFFFF. Entry and return are compared cycle by cycle against a behavioural model. The model also covers requests raised in the middle of a sequence, simultaneous requests, a condition code byte whose mask is already set, and a frame preloaded into memory with the mask clear.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DUMMY,
    ST_PUSH,
    ST_VEC,
    ST_POP,
    ST_FETCH
  } seq_state_e;

  localparam int unsigned STACK_FRAME = 5;
  localparam int unsigned VEC_LEN     = 2;
endpackage

// File: rtl/irq_seq_rst_sync.sv
`timescale 1ns/1ps
module irq_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_seq_ctrl.sv
`timescale 1ns/1ps
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int unsigned DUMMY_CYC = 2,
  parameter int unsigned STEP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_entry,
  input  logic              start_return,
  output seq_state_e        state,
  output logic [STEP_W-1:0] step,
  output logic              launch
);
  localparam seq_state_e ENTRY_FIRST = (DUMMY_CYC == 0) ? ST_PUSH : ST_DUMMY;
  localparam logic [STEP_W-1:0] DUMMY_LAST =
    (DUMMY_CYC == 0) ? '0 : STEP_W'(DUMMY_CYC - 1);
  localparam logic [STEP_W-1:0] FRAME_LAST = STEP_W'(STACK_FRAME - 1);
  localparam logic [STEP_W-1:0] VEC_LAST   = STEP_W'(VEC_LEN - 1);

  seq_state_e        state_nxt;
  logic [STEP_W-1:0] step_nxt;
  logic              seq_en;

  always_comb begin
    state_nxt = state;
    step_nxt  = step + 1'b1;
    launch    = (state == ST_IDLE) && (start_entry || start_return);
    seq_en    = (state != ST_IDLE) || launch;
    unique case (state)
      ST_IDLE: begin
        step_nxt = '0;
        if (start_entry)       state_nxt = ENTRY_FIRST;
        else if (start_return) state_nxt = ST_POP;
      end
      ST_DUMMY: if (step == DUMMY_LAST) begin
        state_nxt = ST_PUSH;
        step_nxt  = '0;
      end
      ST_PUSH: if (step == FRAME_LAST) begin
        state_nxt = ST_VEC;
        step_nxt  = '0;
      end
      ST_VEC: if (step == VEC_LAST) begin
        state_nxt = ST_FETCH;
        step_nxt  = '0;
      end
      ST_POP: if (step == FRAME_LAST) begin
        state_nxt = ST_FETCH;
        step_nxt  = '0;
      end
      ST_FETCH: begin
        state_nxt = ST_IDLE;
        step_nxt  = '0;
      end
      default: begin
        state_nxt = ST_IDLE;
        step_nxt  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else if (seq_en) begin
      state <= state_nxt;
      step  <= step_nxt;
    end
  end
endmodule

// File: rtl/irq_seq_regs.sv
`timescale 1ns/1ps
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MASK_BIT = 3,
  parameter int unsigned STEP_W   = 3,
  localparam int unsigned ADDR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] step,
  input  logic              launch,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] vec_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] snap_ret,
  output logic [DATA_W-1:0] snap_x,
  output logic [DATA_W-1:0] snap_a,
  output logic [DATA_W-1:0] snap_ccr,
  output logic [ADDR_W-1:0] snap_sp,
  output logic [ADDR_W-1:0] snap_vec,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] ccr_out,
  output logic [ADDR_W-1:0] sp_out
);
  localparam logic [DATA_W-1:0] MASK_VAL   = DATA_W'(1) << MASK_BIT;
  localparam logic [ADDR_W-1:0] FRAME_SIZE = ADDR_W'(STACK_FRAME);
  localparam logic [STEP_W-1:0] FRAME_LAST = STEP_W'(STACK_FRAME - 1);

  logic              push_last, pop_c, pop_a, pop_x, pop_h, pop_l, vec_h, vec_l;
  logic              ccr_en, sp_en, hi_en, pc_en;
  logic [DATA_W-1:0] ccr_nxt;
  logic [ADDR_W-1:0] sp_nxt;
  logic [DATA_W-1:0] hi_q;

  always_comb begin
    push_last = (state == ST_PUSH) && (step == FRAME_LAST);
    pop_c     = (state == ST_POP) && (step == STEP_W'(0));
    pop_a     = (state == ST_POP) && (step == STEP_W'(1));
    pop_x     = (state == ST_POP) && (step == STEP_W'(2));
    pop_h     = (state == ST_POP) && (step == STEP_W'(3));
    pop_l     = (state == ST_POP) && (step == FRAME_LAST);
    vec_h     = (state == ST_VEC) && (step == STEP_W'(0));
    vec_l     = (state == ST_VEC) && (step == STEP_W'(1));
    ccr_en    = push_last || pop_c;
    ccr_nxt   = push_last ? (snap_ccr | MASK_VAL) : data_in;
    sp_en     = push_last || pop_l;
    sp_nxt    = push_last ? (snap_sp - FRAME_SIZE) : (snap_sp + FRAME_SIZE);
    hi_en     = vec_h || pop_h;
    pc_en     = vec_l || pop_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_ret <= '0;
      snap_x   <= '0;
      snap_a   <= '0;
      snap_ccr <= '0;
      snap_sp  <= '0;
      snap_vec <= '0;
    end else if (launch) begin
      snap_ret <= pc_in - 1'b1;
      snap_x   <= x_in;
      snap_a   <= a_in;
      snap_ccr <= ccr_in;
      snap_sp  <= sp_in;
      snap_vec <= vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_out <= '0;
      sp_out  <= '0;
      a_out   <= '0;
      x_out   <= '0;
      hi_q    <= '0;
      pc_out  <= '0;
    end else begin
      if (ccr_en) ccr_out <= ccr_nxt;
      if (sp_en)  sp_out  <= sp_nxt;
      if (pop_a)  a_out   <= data_in;
      if (pop_x)  x_out   <= data_in;
      if (hi_en)  hi_q    <= data_in;
      if (pc_en)  pc_out  <= {hi_q, data_in};
    end
  end
endmodule

// File: rtl/irq_seq_bus.sv
`timescale 1ns/1ps
module irq_seq_bus
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned STEP_W  = 3,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] snap_ret,
  input  logic [DATA_W-1:0] snap_x,
  input  logic [DATA_W-1:0] snap_a,
  input  logic [DATA_W-1:0] snap_ccr,
  input  logic [ADDR_W-1:0] snap_sp,
  input  logic [ADDR_W-1:0] snap_vec,
  input  logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic [DATA_W-1:0] data_out,
  output logic              done,
  output logic              busy
);
  logic [ADDR_W-1:0] step_ext;
  logic [DATA_W-1:0] push_byte;

  always_comb begin
    step_ext = ADDR_W'(step);
    unique case (int'(step))
      0:       push_byte = snap_ret[DATA_W-1:0];
      1:       push_byte = snap_ret[ADDR_W-1:DATA_W];
      2:       push_byte = snap_x;
      3:       push_byte = snap_a;
      default: push_byte = snap_ccr;
    endcase
  end

  always_comb begin
    addr     = pc_in;
    rw       = 1'b1;
    data_out = '0;
    done     = 1'b0;
    busy     = (state != ST_IDLE);
    unique case (state)
      ST_IDLE:  addr = pc_in;
      ST_DUMMY: addr = snap_sp;
      ST_PUSH: begin
        addr     = snap_sp - step_ext;
        rw       = 1'b0;
        data_out = push_byte;
      end
      ST_VEC:   addr = snap_vec + step_ext;
      ST_POP:   addr = snap_sp + step_ext + 1'b1;
      ST_FETCH: begin
        addr = pc_out;
        done = 1'b1;
      end
      default:  addr = pc_in;
    endcase
  end
endmodule

// File: rtl/irq_stack_seq.sv
`timescale 1ns/1ps
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DUMMY_CYC = 2,
  parameter int unsigned MASK_BIT  = 3,
  localparam int unsigned ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_entry,
  input  logic              start_return,
  input  logic [ADDR_W-1:0] vec_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr,
  output logic              rw,
  output logic [DATA_W-1:0] data_out,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] ccr_out,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int unsigned STEP_MAX =
    (DUMMY_CYC > STACK_FRAME) ? DUMMY_CYC : STACK_FRAME;
  localparam int unsigned STEP_W = $clog2(STEP_MAX + 1);

  logic              rst_n_sync;
  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic              launch;
  logic [ADDR_W-1:0] snap_ret, snap_sp, snap_vec;
  logic [DATA_W-1:0] snap_x, snap_a, snap_ccr;

  irq_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_seq_ctrl #(.DUMMY_CYC(DUMMY_CYC), .STEP_W(STEP_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .start_entry  (start_entry),
    .start_return (start_return),
    .state        (state),
    .step         (step),
    .launch       (launch)
  );

  irq_seq_regs #(.DATA_W(DATA_W), .MASK_BIT(MASK_BIT), .STEP_W(STEP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .state    (state),
    .step     (step),
    .launch   (launch),
    .pc_in    (pc_in),
    .x_in     (x_in),
    .a_in     (a_in),
    .ccr_in   (ccr_in),
    .sp_in    (sp_in),
    .vec_in   (vec_in),
    .data_in  (data_in),
    .snap_ret (snap_ret),
    .snap_x   (snap_x),
    .snap_a   (snap_a),
    .snap_ccr (snap_ccr),
    .snap_sp  (snap_sp),
    .snap_vec (snap_vec),
    .pc_out   (pc_out),
    .x_out    (x_out),
    .a_out    (a_out),
    .ccr_out  (ccr_out),
    .sp_out   (sp_out)
  );

  irq_seq_bus #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_bus (
    .state    (state),
    .step     (step),
    .pc_in    (pc_in),
    .snap_ret (snap_ret),
    .snap_x   (snap_x),
    .snap_a   (snap_a),
    .snap_ccr (snap_ccr),
    .snap_sp  (snap_sp),
    .snap_vec (snap_vec),
    .pc_out   (pc_out),
    .addr     (addr),
    .rw       (rw),
    .data_out (data_out),
    .done     (done),
    .busy     (busy)
  );
endmodule

// File: rtl/irq_stack_seq_chk.sv
`timescale 1ns/1ps
module irq_stack_seq_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MASK_BIT = 3,
  localparam int unsigned ADDR_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_entry,
  input logic              start_return,
  input logic [ADDR_W-1:0] addr,
  input logic              rw,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] pc_out,
  input logic [DATA_W-1:0] ccr_out
);
  logic [3:0] wr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wr_run <= '0;
    else if (!rw) wr_run <= wr_run + 1'b1;
    else          wr_run <= '0;
  end

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> busy);

  assert_write_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw && $past(!rw)) |-> (addr == $past(addr) - 1'b1));

  assert_write_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rw && $past(!rw)) |-> (wr_run == 4'd5));

  assert_mask_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rw && $past(!rw)) |-> ccr_out[MASK_BIT]);

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_entry || start_return));

  assert_done_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rw && busy && addr == pc_out));

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rw && !done));
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.DATA_W(DATA_W), .MASK_BIT(MASK_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_entry  (start_entry),
  .start_return (start_return),
  .addr         (addr),
  .rw           (rw),
  .done         (done),
  .busy         (busy),
  .pc_out       (pc_out),
  .ccr_out      (ccr_out)
);

// File: tb/sim_irq_stack_seq.sv
`timescale 1ns/1ps
module sim_irq_stack_seq;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int DUMMY = 3;
  localparam int MB = 3;
  localparam logic [7:0] MASK = 8'h01 << MB;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start_entry, start_return;
  logic [AW-1:0] vec_in, pc_in, sp_in, addr, pc_out, sp_out;
  logic [DW-1:0] x_in, a_in, ccr_in, data_in, data_out, x_out, a_out, ccr_out;
  logic          rw, done, busy;

  irq_stack_seq #(.DATA_W(DW), .DUMMY_CYC(DUMMY), .MASK_BIT(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_return(start_return),
    .vec_in(vec_in), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
    .sp_in(sp_in), .data_in(data_in), .addr(addr), .rw(rw), .data_out(data_out),
    .done(done), .busy(busy), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
    .ccr_out(ccr_out), .sp_out(sp_out)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic [15:0] a;
    logic        w;
    logic [7:0]  d;
    logic        dn;
    logic        cc_en;
    logic [31:0] cc_tag;
    logic [7:0]  cc;
  } cyc_t;

  cyc_t       q[$];
  logic [7:0] mem [int];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  function automatic logic [7:0] rd(input logic [15:0] ad);
    return mem.exists(int'(ad)) ? mem[int'(ad)] : 8'h00;
  endfunction

  task automatic chk(input logic [31:0] tag, input bit ok,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic serve_mem();
    data_in = rd(addr);
    if (!rw) mem[int'(addr)] = data_out;
  endtask

  // R8: idle bus behaviour checked at the ports
  task automatic idle_chk();
    logic [47:0] act, exp;
    act = {22'd0, addr, rw, data_out, done, busy};
    exp = {22'd0, pc_in, 1'b1, 8'h00, 1'b0, 1'b0};
    chk("R8", act == exp, act, exp);
  endtask

  function automatic cyc_t mk(input logic [31:0] tag, input logic [15:0] a,
                              input logic w, input logic [7:0] d, input logic dn);
    cyc_t c;
    c.tag = tag; c.a = a; c.w = w; c.d = d; c.dn = dn;
    c.cc_en = 1'b0; c.cc_tag = "R4"; c.cc = 8'h00;
    return c;
  endfunction

  task automatic cmp_cycle(input cyc_t e);
    logic [47:0] act, exp;
    act = {22'd0, addr, rw, (rw ? 8'h00 : data_out), done, busy};
    exp = {22'd0, e.a, ~e.w, (e.w ? e.d : 8'h00), e.dn, 1'b1};
    chk(e.tag, act == exp, act, exp);
    if (e.cc_en) chk(e.cc_tag, ccr_out == e.cc, {40'd0, ccr_out}, {40'd0, e.cc});
  endtask

  task automatic run_entry(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                           input logic [7:0] ccr, input logic [15:0] sp,
                           input logic [15:0] vec, input bit both);
    logic [15:0] ret, hv;
    cyc_t        c;
    int          idx;
    @(negedge clk);
    idle_chk();
    serve_mem();
    pc_in = pc; x_in = x; a_in = a; ccr_in = ccr; sp_in = sp; vec_in = vec;
    start_entry = 1'b1; start_return = both;
    ret = pc - 16'd1;
    hv  = {rd(vec), rd(vec + 16'd1)};
    for (int i = 0; i < DUMMY; i++) q.push_back(mk("R3", sp, 1'b0, 8'h00, 1'b0));
    q.push_back(mk("R3", sp,          1'b1, ret[7:0],  1'b0));
    q.push_back(mk("R3", sp - 16'd1,  1'b1, ret[15:8], 1'b0));
    q.push_back(mk("R3", sp - 16'd2,  1'b1, x,         1'b0));
    q.push_back(mk("R3", sp - 16'd3,  1'b1, a,         1'b0));
    q.push_back(mk("R3", sp - 16'd4,  1'b1, ccr,       1'b0));
    c = mk("R5", vec, 1'b0, 8'h00, 1'b0);
    c.cc_en = 1'b1; c.cc_tag = "R4"; c.cc = ccr | MASK;
    q.push_back(c);
    q.push_back(mk("R5", vec + 16'd1, 1'b0, 8'h00, 1'b0));
    q.push_back(mk("R7", hv, 1'b0, 8'h00, 1'b1));
    idx = 0;
    while (q.size() > 0) begin
      @(negedge clk);
      cmp_cycle(q.pop_front());
      serve_mem();
      // R2: requests while busy must be ignored
      start_entry  = (idx == 4);
      start_return = (idx == 2);
      idx++;
    end
    @(negedge clk);
    idle_chk();
    serve_mem();
    chk("R5", pc_out == hv, {32'd0, pc_out}, {32'd0, hv});
    chk("R4", sp_out == sp - 16'd5, {32'd0, sp_out}, {32'd0, sp - 16'd5});
    chk("R4", ccr_out == (ccr | MASK), {40'd0, ccr_out}, {40'd0, ccr | MASK});
  endtask

  task automatic run_return(input logic [15:0] sp, input logic [7:0] ccr, input logic [7:0] a,
                            input logic [7:0] x, input logic [15:0] pc);
    cyc_t c;
    @(negedge clk);
    idle_chk();
    serve_mem();
    sp_in = sp; start_return = 1'b1;
    q.push_back(mk("R6", sp + 16'd1, 1'b0, 8'h00, 1'b0));
    c = mk("R6", sp + 16'd2, 1'b0, 8'h00, 1'b0);
    c.cc_en = 1'b1; c.cc_tag = "R9"; c.cc = ccr;
    q.push_back(c);
    q.push_back(mk("R6", sp + 16'd3, 1'b0, 8'h00, 1'b0));
    q.push_back(mk("R6", sp + 16'd4, 1'b0, 8'h00, 1'b0));
    q.push_back(mk("R6", sp + 16'd5, 1'b0, 8'h00, 1'b0));
    q.push_back(mk("R7", pc, 1'b0, 8'h00, 1'b1));
    while (q.size() > 0) begin
      @(negedge clk);
      cmp_cycle(q.pop_front());
      serve_mem();
      start_return = 1'b0;
    end
    @(negedge clk);
    idle_chk();
    serve_mem();
    chk("R6", pc_out == pc, {32'd0, pc_out}, {32'd0, pc});
    chk("R6", a_out == a, {40'd0, a_out}, {40'd0, a});
    chk("R6", x_out == x, {40'd0, x_out}, {40'd0, x});
    chk("R6", sp_out == sp + 16'd5, {32'd0, sp_out}, {32'd0, sp + 16'd5});
    chk("R9", ccr_out[MB] == ccr[MB], {47'd0, ccr_out[MB]}, {47'd0, ccr[MB]});
  endtask

  initial begin
    rst_n = 1'b0; start_entry = 1'b0; start_return = 1'b0;
    vec_in = '0; pc_in = 16'h4321; sp_in = '0; x_in = '0; a_in = '0; ccr_in = '0;
    data_in = '0;
    mem[16'hFFFA] = 8'h80; mem[16'hFFFB] = 8'h40;
    mem[16'hFFF8] = 8'hC0; mem[16'hFFF9] = 8'h01;
    mem[16'h2001] = 8'h04; mem[16'h2002] = 8'h5A; mem[16'h2003] = 8'hA5;
    mem[16'h2004] = 8'hBE; mem[16'h2005] = 8'hEF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {busy, done, rw} == 3'b001, {45'd0, busy, done, rw}, 48'd1);
    chk("R1", {pc_out, x_out, a_out, ccr_out, sp_out} == '0,
        {8'd0, pc_out, x_out, a_out}, 48'd0);
    chk("R1", {ccr_out, sp_out} == '0, {24'd0, ccr_out, sp_out}, 48'd0);
    // entry with mask clear, mid-sequence requests ignored (R2)
    run_entry(16'h1235, 8'h11, 8'h22, 8'h60, 16'h00FF, 16'hFFFA, 1'b0);
    // return from that frame, mask comes back clear (R9)
    run_return(16'h00FA, 8'h60, 8'h22, 8'h11, 16'h1234);
    // both requests at once: entry wins (R2); stack wraps below zero (R3)
    run_entry(16'h0000, 8'h33, 8'h44, 8'h08, 16'h0002, 16'hFFF8, 1'b1);
    // return wrapping up through 0xFFFF (R6)
    run_return(16'hFFFD, 8'h08, 8'h44, 8'h33, 16'hFFFF);
    // preloaded frame with mask clear (R6, R9)
    run_return(16'h2000, 8'h04, 8'h5A, 8'hA5, 16'hBEEF);
    repeat (2) begin
      @(negedge clk);
      idle_chk();
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule